// File: doc/BRIEF.md
# Dual Reloading Timer Interrupt Unit

This block provides two independent down-counting timer channels behind a simple single-cycle 32-bit register port. Each channel has a reload value, a live count and a control word. The control word carries a two-bit operation: load the count from the reload value, hold, or run. It also carries a three-bit count-rate select. A running channel decrements once for every clock cycle in which its selected tick-enable input is high. When a tick arrives while the count is zero, the channel reloads itself from its reload value and flags an expiry, so a channel with reload value N expires every N+1 ticks.

Expiries set sticky status bits. Software clears them by writing ones to an acknowledge address; that address holds nothing and always reads zero. A two-bit mask gates the status onto a single interrupt line, and the gated value can be read back. A free-running timestamp counter, which advances on every clock, is readable. Rate sources come from outside as tick-enable pulses, so the block contains no clock generation.

Top module: `dual_tick_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every readable register reads zero, the count-rate channels are stopped, and `irq` is low.
- R2: Writing 0x00 (channel 0) or 0x10 (channel 1) stores the low CNT_W bits as the reload value, which reads back at the same address. A control write with operation 0 (bits [1:0]) copies the reload value into the count, which is readable at 0x04 or 0x14. After such a write the channel does not count.
- R3: With operation 2 (run) in the control register (0x08 or 0x18), the count drops by one on each clock in which the selected tick is high. With operation 1 (hold) the count is frozen.
- R4: Control bits [4:2] select the tick source. Codes 4, 5, 6 and 7 pick `rate_tick[0]` to `rate_tick[3]`. Code 0 picks the channel's own `ext_tick` bit. Code 1 never ticks.
- R5: A selected tick that arrives while a running channel's count is zero reloads the count from the reload value and sets status bit 0 (channel 0) or bit 1 (channel 1). Raw status is readable at 0x50.
- R6: Writing 0x4C clears each status bit that is written as 1 and leaves the others unchanged. An expiry in the same cycle wins over the clear. Address 0x4C always reads zero.
- R7: The mask at 0x48 keeps bits [1:0] of the written value. Reading 0x54 returns status AND mask, and `irq` is high exactly when that value is nonzero.
- R8: A control write with operation 3, or with rate code 2 or 3, is dropped. The control register, the count and the counting behaviour stay unchanged.
- R9: The timestamp at 0x38 increments by one every clock and wraps at 2^TS_W.
- R10: Writes to unmapped or read-only addresses (0x04, 0x14, 0x38, 0x50, 0x54) change nothing. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 8 | Byte address of the 32-bit register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rate_tick | input | 4 | Tick enables of the four shared rate sources |
| ext_tick | input | 2 | Per-channel external tick enables |
| irq | output | 1 | High while any masked status bit is set |

## Verification
The bench builds the block with CNT_W=8 and TS_W=10. With the narrow count, the truncation of large reload writes and expiry chains with reload values from 0 to 7 occur thousands of times in a short run. With the narrow timestamp, the counter wraps many times in a run, so its roll-over is checked as well as its steady increment. Random writes include illegal control codes, read-only and unmapped addresses, and acknowledges that land in the same cycle as an expiry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int OP_W   = 2;
   localparam int RATE_W = 3;
   localparam int CTRL_W = OP_W + RATE_W;
   localparam int NCH    = 2;
   localparam int NRATE  = 4;

   typedef enum logic [OP_W-1:0] {
      OP_LOAD = 2'd0,
      OP_HOLD = 2'd1,
      OP_RUN  = 2'd2,
      OP_BAD  = 2'd3
   } tmr_op_e;

   localparam logic [7:0] A_DIV0  = 8'h00;
   localparam logic [7:0] A_CNT0  = 8'h04;
   localparam logic [7:0] A_CTL0  = 8'h08;
   localparam logic [7:0] A_DIV1  = 8'h10;
   localparam logic [7:0] A_CNT1  = 8'h14;
   localparam logic [7:0] A_CTL1  = 8'h18;
   localparam logic [7:0] A_STAMP = 8'h38;
   localparam logic [7:0] A_MASK  = 8'h48;
   localparam logic [7:0] A_ACK   = 8'h4C;
   localparam logic [7:0] A_RAW   = 8'h50;
   localparam logic [7:0] A_GATED = 8'h54;

   // a control word is accepted only with a legal op and a defined rate code
   function automatic logic ctrl_legal(input logic [CTRL_W-1:0] w);
      logic [RATE_W-1:0] r;
      r = w[CTRL_W-1:OP_W];
      return (w[OP_W-1:0] != OP_BAD) && (r != 3'd2) && (r != 3'd3);
   endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 div_we,
   input  logic [CNT_W-1:0]     div_wdata,
   input  logic                 ctrl_we,
   input  logic [CTRL_W-1:0]    ctrl_wdata,
   input  logic [NRATE-1:0]     rate_tick,
   input  logic                 ext_tick,
   output logic [CNT_W-1:0]     div_q,
   output logic [CNT_W-1:0]     count_q,
   output logic [CTRL_W-1:0]    ctrl_q,
   output logic                 expire
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("tmr_chan: CNT_W must lie in 2..32");
   end

   logic              ctrl_hit;
   logic              running;
   logic              tick_sel;
   logic [RATE_W-1:0] rate_code;

   assign ctrl_hit  = ctrl_we && ctrl_legal(ctrl_wdata);
   assign running   = (ctrl_q[OP_W-1:0] == OP_RUN);
   assign rate_code = ctrl_q[CTRL_W-1:OP_W];

   always_comb begin
      unique case (rate_code)
         3'd0:    tick_sel = ext_tick;
         3'd4:    tick_sel = rate_tick[0];
         3'd5:    tick_sel = rate_tick[1];
         3'd6:    tick_sel = rate_tick[2];
         3'd7:    tick_sel = rate_tick[3];
         default: tick_sel = 1'b0;
      endcase
   end

   assign expire = running && tick_sel && (count_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (div_we) begin
         div_q <= div_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_hit) begin
         ctrl_q <= ctrl_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (ctrl_hit && (ctrl_wdata[OP_W-1:0] == OP_LOAD)) begin
         count_q <= div_q;
      end else if (running && tick_sel) begin
         if (count_q == '0) begin
            count_q <= div_q;
         end else begin
            count_q <= count_q - 1'b1;
         end
      end
   end

   // R3
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && tick_sel && (count_q != '0) && !ctrl_we)
      |=> (count_q == $past(count_q) - 1'b1));

   // R3
   hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctrl_q[OP_W-1:0] == OP_HOLD) && !ctrl_we) |=> $stable(count_q));

   // R5
   expire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !ctrl_we) |=> (count_q == $past(div_q)));

   // R8
   bad_ctrl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && !ctrl_legal(ctrl_wdata)) |=> $stable(ctrl_q));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
   parameter int NBITS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] set_bits,
   input  logic             ack_we,
   input  logic [NBITS-1:0] ack_bits,
   input  logic             mask_we,
   input  logic [NBITS-1:0] mask_bits,
   output logic [NBITS-1:0] status_q,
   output logic [NBITS-1:0] mask_q,
   output logic [NBITS-1:0] gated,
   output logic             irq
);
   if (NBITS < 1 || NBITS > 32) begin : g_bad_bits
      $error("tmr_irq: NBITS must lie in 1..32");
   end

   logic [NBITS-1:0] clr;

   assign clr   = ack_we ? ack_bits : '0;
   assign gated = status_q & mask_q;
   assign irq   = |gated;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
      end else begin
         status_q <= (status_q & ~clr) | set_bits;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (mask_we) begin
         mask_q <= mask_bits;
      end
   end

   // R5
   status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_bits != '0) |=> ((status_q & $past(set_bits)) == $past(set_bits)));

   // R6
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && ((ack_bits & ~set_bits) != '0))
      |=> ((status_q & $past(ack_bits & ~set_bits)) == '0));

   // R6
   no_ack_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_we |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/tmr_stamp.sv
module tmr_stamp #(
   parameter int TS_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TS_W-1:0] stamp_q
);
   if (TS_W < 4 || TS_W > 64) begin : g_bad_ts
      $error("tmr_stamp: TS_W must lie in 4..64");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stamp_q <= '0;
      end else begin
         stamp_q <= stamp_q + 1'b1;
      end
   end

   // R9
   stamp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (stamp_q == $past(stamp_q) + 1'b1));
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int TS_W  = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic [7:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic [3:0]  rate_tick,
   input  logic [1:0]  ext_tick,
   output logic        irq
);
   localparam logic [7:0] DIV_A [NCH] = '{A_DIV0, A_DIV1};
   localparam logic [7:0] CTL_A [NCH] = '{A_CTL0, A_CTL1};

   logic [CNT_W-1:0]  div_v   [NCH];
   logic [CNT_W-1:0]  cnt_v   [NCH];
   logic [CTRL_W-1:0] ctl_v   [NCH];
   logic [NCH-1:0]    exp_v;
   logic [NCH-1:0]    status_v;
   logic [NCH-1:0]    mask_v;
   logic [NCH-1:0]    gated_v;
   logic [TS_W-1:0]   stamp_v;
   logic [31:0]       stamp_rd;

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      tmr_chan #(.CNT_W(CNT_W)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .div_we     (bus_wr && (bus_addr == DIV_A[c])),
         .div_wdata  (bus_wdata[CNT_W-1:0]),
         .ctrl_we    (bus_wr && (bus_addr == CTL_A[c])),
         .ctrl_wdata (bus_wdata[CTRL_W-1:0]),
         .rate_tick  (rate_tick),
         .ext_tick   (ext_tick[c]),
         .div_q      (div_v[c]),
         .count_q    (cnt_v[c]),
         .ctrl_q     (ctl_v[c]),
         .expire     (exp_v[c])
      );
   end

   tmr_irq #(.NBITS(NCH)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_bits  (exp_v),
      .ack_we    (bus_wr && (bus_addr == A_ACK)),
      .ack_bits  (bus_wdata[NCH-1:0]),
      .mask_we   (bus_wr && (bus_addr == A_MASK)),
      .mask_bits (bus_wdata[NCH-1:0]),
      .status_q  (status_v),
      .mask_q    (mask_v),
      .gated     (gated_v),
      .irq       (irq)
   );

   tmr_stamp #(.TS_W(TS_W)) u_stamp (
      .clk     (clk),
      .rst_n   (rst_n),
      .stamp_q (stamp_v)
   );

   if (TS_W >= 32) begin : g_ts_trunc
      assign stamp_rd = stamp_v[31:0];
   end else begin : g_ts_ext
      assign stamp_rd = 32'(stamp_v);
   end

   always_comb begin
      unique case (bus_addr)
         A_DIV0:  bus_rdata = 32'(div_v[0]);
         A_CNT0:  bus_rdata = 32'(cnt_v[0]);
         A_CTL0:  bus_rdata = 32'(ctl_v[0]);
         A_DIV1:  bus_rdata = 32'(div_v[1]);
         A_CNT1:  bus_rdata = 32'(cnt_v[1]);
         A_CTL1:  bus_rdata = 32'(ctl_v[1]);
         A_STAMP: bus_rdata = stamp_rd;
         A_MASK:  bus_rdata = 32'(mask_v);
         A_RAW:   bus_rdata = 32'(status_v);
         A_GATED: bus_rdata = 32'(gated_v);
         default: bus_rdata = '0;
      endcase
   end

   // R7
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == A_MASK) && (bus_wdata[NCH-1:0] == '0)) |=> !irq);

   // R10
   ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == A_RAW) && (exp_v == '0)) |=> $stable(status_v));
endmodule

// File: tb/dual_tick_timer_test.sv
module dual_tick_timer_test;
   localparam int CLK_P = 10;
   localparam int CW = 8;
   localparam int TW = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  rate_tick = '0;
   logic [1:0]  ext_tick = '0;
   logic        irq;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   string pend_tag = "R1";

   dual_tick_timer #(.CNT_W(CW), .TS_W(TW)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rate_tick(rate_tick),
      .ext_tick(ext_tick), .irq(irq)
   );

   always #(CLK_P/2) clk = ~clk;

   // reference state, built from the requirements
   logic [CW-1:0] m_div [2];
   logic [CW-1:0] m_cnt [2];
   logic [4:0]    m_ctl [2];
   logic [1:0]    m_stat, m_mask;
   logic [TW-1:0] m_ts;

   function automatic logic pick_tick(input logic [2:0] code, input logic [3:0] rt, input logic et);
      case (code)
         3'd0: return et;
         3'd4: return rt[0];
         3'd5: return rt[1];
         3'd6: return rt[2];
         3'd7: return rt[3];
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [31:0] m_read(input logic [7:0] a);
      case (a)
         8'h00: return 32'(m_div[0]);
         8'h04: return 32'(m_cnt[0]);
         8'h08: return 32'(m_ctl[0]);
         8'h10: return 32'(m_div[1]);
         8'h14: return 32'(m_cnt[1]);
         8'h18: return 32'(m_ctl[1]);
         8'h38: return 32'(m_ts);
         8'h48: return 32'(m_mask);
         8'h50: return 32'(m_stat);
         8'h54: return 32'(m_stat & m_mask);
         default: return 32'h0;
      endcase
   endfunction

   function automatic string req_of(input logic [7:0] a);
      case (a)
         8'h00, 8'h10: return "R2";
         8'h04, 8'h14: return "R3";
         8'h08, 8'h18: return "R8";
         8'h38: return "R9";
         8'h48, 8'h54: return "R7";
         8'h50: return "R5";
         default: return "R10";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) begin
            m_div[c] = '0; m_cnt[c] = '0; m_ctl[c] = '0;
         end
         m_stat = '0; m_mask = '0; m_ts = '0;
      end else begin
         logic [1:0] ex;
         for (int c = 0; c < 2; c++) begin
            logic tk, run;
            logic [CW-1:0] nc;
            logic [7:0] ca, da;
            ca = (c == 0) ? 8'h08 : 8'h18;
            da = (c == 0) ? 8'h00 : 8'h10;
            run = (m_ctl[c][1:0] == 2'd2);
            tk = pick_tick(m_ctl[c][4:2], rate_tick, ext_tick[c]);
            ex[c] = run && tk && (m_cnt[c] == '0);
            nc = m_cnt[c];
            if (run && tk) nc = ex[c] ? m_div[c] : m_cnt[c] - 1'b1;
            if (bus_wr && bus_addr == ca && bus_wdata[1:0] != 2'd3 &&
                bus_wdata[4:2] != 3'd2 && bus_wdata[4:2] != 3'd3) begin
               m_ctl[c] = bus_wdata[4:0];
               if (bus_wdata[1:0] == 2'd0) nc = m_div[c];
            end
            m_cnt[c] = nc;
            if (bus_wr && bus_addr == da) m_div[c] = bus_wdata[CW-1:0];
         end
         if (bus_wr && bus_addr == 8'h4C) m_stat = m_stat & ~bus_wdata[1:0];
         m_stat = m_stat | ex;
         if (bus_wr && bus_addr == 8'h48) m_mask = bus_wdata[1:0];
         m_ts = m_ts + 1'b1;
      end
   end

   task automatic check_now();
      logic [31:0] e;
      string t;
      e = m_read(bus_addr);
      t = (pend_tag != "") ? pend_tag : req_of(bus_addr);
      total++;
      if (bus_rdata !== e) begin
         bad++;
         $display("FAIL %s addr=%h actual=%h expected=%h", t, bus_addr, bus_rdata, e);
      end
      total++;
      if (irq !== ((m_stat & m_mask) != 0)) begin
         bad++;
         $display("FAIL R7 irq actual=%b expected=%b", irq, (m_stat & m_mask) != 0);
      end
   endtask

   task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [3:0] rt, input logic [1:0] et, input string tag);
      @(negedge clk);
      check_now();
      bus_wr = wr; bus_addr = a; bus_wdata = d; rate_tick = rt; ext_tick = et;
      pend_tag = tag;
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      step(1'b0, a, 32'h0, 4'h0, 2'b00, tag);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
      step(1'b1, a, d, 4'h0, 2'b00, tag);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   localparam logic [7:0] ADDRS [16] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18,
      8'h38, 8'h48, 8'h4C, 8'h50, 8'h54, 8'h0C, 8'h20, 8'h5C, 8'hFC, 8'h4C};

   initial begin
      logic [31:0] seed;
      seed = $urandom(32'd4242);
      // R1: reads during and right after reset
      foreach (ADDRS[i]) rd(ADDRS[i], "R1");
      @(negedge clk); rst_n = 1'b1;
      rd(8'h04, "R1"); rd(8'h50, "R1"); rd(8'h48, "R1");
      // R2: reload write with truncation, then load
      wr(8'h00, 32'h0000_1234, "R2"); rd(8'h00, "R2");
      wr(8'h08, 32'h0000_0000, "R2"); rd(8'h04, "R2");
      step(1'b0, 8'h04, 0, 4'hF, 2'b11, "R2"); rd(8'h04, "R2");
      // R8: illegal op and undefined rate codes
      wr(8'h08, 32'h0000_0013, "R8"); rd(8'h08, "R8");
      wr(8'h08, 32'h0000_000A, "R8"); rd(8'h08, "R8");
      wr(8'h08, 32'h0000_000E, "R8"); rd(8'h08, "R8");
      // R4: each rate source for channel 0, reload 3
      wr(8'h00, 32'd3, "R4"); wr(8'h08, 32'h0, "R4");
      for (int code = 4; code < 8; code++) begin
         wr(8'h08, 32'((code << 2) | 2), "R4");
         for (int k = 0; k < 4; k++) step(1'b0, 8'h04, 0, 4'(1 << (k)), 2'b00, "R4");
         step(1'b0, 8'h04, 0, 4'h0, 2'b01, "R4");
      end
      wr(8'h08, 32'h2, "R4");
      step(1'b0, 8'h04, 0, 4'h0, 2'b01, "R4"); step(1'b0, 8'h04, 0, 4'h0, 2'b10, "R4");
      wr(8'h08, 32'h6, "R4");
      step(1'b0, 8'h04, 0, 4'hF, 2'b11, "R4"); rd(8'h04, "R4");
      // R5/R6/R7: channel 1 expiry, mask, ack racing an expiry
      wr(8'h48, 32'hFFFF_FFFF, "R7"); wr(8'h10, 32'd0, "R5"); wr(8'h18, 32'h12, "R5");
      step(1'b0, 8'h50, 0, 4'h1, 2'b00, "R5"); rd(8'h54, "R7");
      step(1'b1, 8'h4C, 32'h2, 4'h1, 2'b00, "R6"); rd(8'h50, "R6");
      wr(8'h18, 32'h11, "R6");
      wr(8'h4C, 32'h2, "R6"); rd(8'h50, "R6"); rd(8'h4C, "R6");
      // R10: writes to read-only and unmapped addresses
      wr(8'h50, 32'h3, "R10"); wr(8'h38, 32'h0, "R10"); wr(8'h14, 32'h55, "R10");
      wr(8'h20, 32'hFF, "R10"); rd(8'h20, "R10"); rd(8'h50, "R10"); rd(8'h38, "R9");
      // random phase
      for (int n = 0; n < 20000; n++) begin
         logic [7:0] a;
         logic [31:0] d;
         logic w;
         a = ADDRS[$urandom_range(0, 15)];
         w = ($urandom_range(0, 9) < 3);
         d = $urandom;
         if (a == 8'h00 || a == 8'h10)
            d = ($urandom_range(0, 7) == 0) ? $urandom : 32'($urandom_range(0, 7));
         if ((a == 8'h08 || a == 8'h18) && $urandom_range(0, 3) != 0)
            d = 32'({3'($urandom_range(4, 7)), 2'd2});
         step(w, a, d, 4'($urandom), 2'($urandom), "");
      end
      rd(8'h00, "");
      @(negedge clk); check_now();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule